// File: doc/BRIEF.md
# Patchable Accelerator Control Sequencer

This block sequences the control of a fixed-function accelerator. Each step is selected by a program counter. Normally an external hardwired schedule supplies the control word and the next program counter for that step. The sequencer adds a small writable patch memory and a bank of redirect entries, so that the behaviour can be changed after fabrication without touching the hardwired logic.

A redirect entry holds a program-counter value, a target and a valid flag. When the current program counter equals the value of a valid entry, the next program counter becomes that entry's target. A programmable boundary splits the program-counter space. Above the boundary, both the control word and the next program counter come from the patch-memory word selected by the low bits of the program counter. Because each patch word carries its own next address, a patched sequence can jump back into hardwired steps.

Software loads the patch memory, the entries and the boundary through a simple write port while the sequencer is idle. A start pulse then runs the schedule. A halt input pauses the schedule. A one-cycle done pulse marks the end of the run.

Top module: `patch_seq`

## Requirements
- R1: After reset, pc is 0, ctrl is the no-operation word (all zeros) and done is 0. All redirect entries are invalid and the boundary is 63, so a run follows the hardwired schedule unchanged.
- R2: A start pulse while idle loads pc with 1 at the next clock edge. A start pulse while running has no effect on the running sequence.
- R3: While running, with pc at or below the boundary and no valid entry matching, each clock edge loads ctrl with hw_ctrl and pc with hw_next, both taken from the cycle before that edge.
- R4: While running, with pc above the boundary, each edge loads ctrl from bits [15:0] and the next pc from bits [21:16] of the patch word at index pc[3:0].
- R5: A valid entry whose pc value equals the current pc replaces the next pc with the entry's target. The control word still comes from the source chosen by R3 or R4.
- R6: When several valid entries match, the entry with the lowest index wins. Entries whose valid flag is 0 never match.
- R7: A step whose next pc is 63 loads pc with 63 and raises done for exactly one cycle. The sequencer then returns to idle, and ctrl is the no-operation word on every cycle after an idle edge.
- R8: While running, halt holds pc unchanged and drives ctrl to the no-operation word. When halt is released, the schedule resumes from the held pc.
- R9: A write with cfg_we set stores cfg_wdata according to cfg_addr[5:4] while idle. Code 0 writes patch word cfg_addr[3:0]. Code 1 writes entry cfg_addr[3:0] with pc value in bits [5:0], target in bits [11:6] and valid in bit 12. Code 2 writes the boundary from bits [5:0]. Writes while running are ignored.
- R10: The control word passes bit-exactly. Its layout is opcode [15:12], register-file read enable [11], register-file write enable [10], read address [9:7], write address [6:4] and unit enables [3:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse, accepted while idle |
| halt | input | 1 | Pause the running schedule |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 6 | Configuration address: region in bits [5:4], slot in bits [3:0] |
| cfg_wdata | input | 22 | Configuration write data |
| hw_ctrl | input | 16 | Control word from the hardwired schedule for the current pc |
| hw_next | input | 6 | Next pc from the hardwired schedule for the current pc |
| pc | output | 6 | Registered program counter |
| ctrl | output | 16 | Registered control word |
| done | output | 1 | One-cycle end-of-run pulse |

## Verification
The bench runs the schedule with the boundary swept over every value from 0 to 7. This shows where control passes from the hardwired table to the patch memory, and it shows the exact strict-greater-than comparison at the boundary.

Redirect patterns cover four cases:
- a single entry that jumps into patch memory and returns to hardwired steps;
- two valid entries on the same pc, which shows the priority;
- the same pair with the winner invalidated;
- an invalid entry, which must be ignored.

Further runs inject a halt, a start pulse while running and a configuration write while running. These separate frozen, restarted and reconfigured behaviour from the expected trace.

// File: rtl/psq_pkg.sv
package psq_pkg;

    localparam int PC_W     = 6;
    localparam int PM_AW    = 4;
    localparam int PM_DEPTH = 1 << PM_AW;
    localparam int N_ENT    = 4;
    localparam int CFG_AW   = 6;
    localparam int RG_W     = CFG_AW - PM_AW;
    localparam int OP_W     = 4;
    localparam int RF_AW    = 3;
    localparam int UNIT_W   = 4;

    typedef logic [PC_W-1:0] pc_t;

    typedef struct packed {
        logic [OP_W-1:0]   op;
        logic              rf_re;
        logic              rf_we;
        logic [RF_AW-1:0]  rf_ra;
        logic [RF_AW-1:0]  rf_wa;
        logic [UNIT_W-1:0] unit_en;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    typedef struct packed {
        pc_t   nxt;
        ctrl_t ctrl;
    } pword_t;

    localparam int CFG_DW = $bits(pword_t);

    typedef struct packed {
        logic valid;
        pc_t  tgt;
        pc_t  at;
    } entry_t;

    localparam int ENT_W = $bits(entry_t);

    localparam pc_t   PC_TERM  = '1;
    localparam pc_t   PC_FIRST = pc_t'(1);
    localparam ctrl_t CTRL_NOP = '0;

    localparam logic [RG_W-1:0] RG_PM  = RG_W'(0);
    localparam logic [RG_W-1:0] RG_ENT = RG_W'(1);
    localparam logic [RG_W-1:0] RG_BND = RG_W'(2);

    function automatic entry_t to_entry(input logic [CFG_DW-1:0] d);
        return entry_t'(d[ENT_W-1:0]);
    endfunction

endpackage

// File: rtl/psq_cfg_store.sv
module psq_cfg_store
    import psq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_ok,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [CFG_DW-1:0] cfg_wdata,
    input  logic [PM_AW-1:0]  rd_idx,
    output pword_t            pm_word,
    output entry_t            entries [N_ENT],
    output pc_t               boundary
);

    logic [RG_W-1:0]  region;
    logic [PM_AW-1:0] slot;
    logic             wr;

    assign region = cfg_addr[CFG_AW-1:PM_AW];
    assign slot   = cfg_addr[PM_AW-1:0];
    assign wr     = cfg_we & wr_ok;

    pword_t mem [PM_DEPTH];

    always_ff @(posedge clk) begin
        if (wr && region == RG_PM) begin
            mem[slot] <= pword_t'(cfg_wdata);
        end
    end

    assign pm_word = mem[rd_idx];

    for (genvar k = 0; k < N_ENT; k++) begin : g_ent
        always_ff @(posedge clk) begin
            if (rst) begin
                entries[k] <= '0;
            end else if (wr && region == RG_ENT && slot == PM_AW'(k)) begin
                entries[k] <= to_entry(cfg_wdata);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            boundary <= '1;
        end else if (wr && region == RG_BND) begin
            boundary <= cfg_wdata[PC_W-1:0];
        end
    end

endmodule

// File: rtl/psq_match.sv
module psq_match
    import psq_pkg::*;
(
    input  pc_t    pc,
    input  entry_t entries [N_ENT],
    output logic   hit,
    output pc_t    tgt
);

    always_comb begin
        hit = 1'b0;
        tgt = '0;
        for (int k = N_ENT - 1; k >= 0; k--) begin
            if (entries[k].valid && entries[k].at == pc) begin
                hit = 1'b1;
                tgt = entries[k].tgt;
            end
        end
    end

endmodule

// File: rtl/psq_step.sv
module psq_step
    import psq_pkg::*;
(
    input  pc_t               pc,
    input  pc_t               boundary,
    input  logic [CTRL_W-1:0] hw_ctrl,
    input  pc_t               hw_next,
    input  pword_t            pm_word,
    input  logic              hit,
    input  pc_t               tgt,
    output ctrl_t             step_ctrl,
    output pc_t               step_next
);

    logic use_patch;
    pc_t  base_next;

    assign use_patch = pc > boundary;
    assign step_ctrl = use_patch ? pm_word.ctrl : ctrl_t'(hw_ctrl);
    assign base_next = use_patch ? pm_word.nxt : hw_next;
    assign step_next = hit ? tgt : base_next;

endmodule

// File: rtl/patch_seq.sv
module patch_seq
    import psq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              halt,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [CFG_DW-1:0] cfg_wdata,
    input  logic [CTRL_W-1:0] hw_ctrl,
    input  logic [PC_W-1:0]   hw_next,
    output logic [PC_W-1:0]   pc,
    output logic [CTRL_W-1:0] ctrl,
    output logic              done
);

    logic   running_q;
    pc_t    pc_q;
    ctrl_t  ctrl_q;
    logic   done_q;

    pword_t pm_word;
    entry_t entries [N_ENT];
    pc_t    boundary;
    logic   hit;
    pc_t    tgt;
    ctrl_t  step_ctrl;
    pc_t    step_next;

    psq_cfg_store u_store (
        .clk       (clk),
        .rst       (rst),
        .wr_ok     (~running_q),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .rd_idx    (pc_q[PM_AW-1:0]),
        .pm_word   (pm_word),
        .entries   (entries),
        .boundary  (boundary)
    );

    psq_match u_match (
        .pc      (pc_q),
        .entries (entries),
        .hit     (hit),
        .tgt     (tgt)
    );

    psq_step u_step (
        .pc        (pc_q),
        .boundary  (boundary),
        .hw_ctrl   (hw_ctrl),
        .hw_next   (hw_next),
        .pm_word   (pm_word),
        .hit       (hit),
        .tgt       (tgt),
        .step_ctrl (step_ctrl),
        .step_next (step_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            running_q <= 1'b0;
            pc_q      <= '0;
            ctrl_q    <= CTRL_NOP;
            done_q    <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (!running_q) begin
                ctrl_q <= CTRL_NOP;
                if (start) begin
                    running_q <= 1'b1;
                    pc_q      <= PC_FIRST;
                end
            end else if (halt) begin
                ctrl_q <= CTRL_NOP;
            end else begin
                ctrl_q <= step_ctrl;
                pc_q   <= step_next;
                if (step_next == PC_TERM) begin
                    running_q <= 1'b0;
                    done_q    <= 1'b1;
                end
            end
        end
    end

    assign pc   = pc_q;
    assign ctrl = ctrl_q;
    assign done = done_q;

endmodule

// File: rtl/psq_checker.sv
module psq_checker
    import psq_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              halt,
    input logic              running,
    input logic [PC_W-1:0]   pc,
    input logic [CTRL_W-1:0] ctrl,
    input logic              done,
    input logic [PC_W-1:0]   step_next,
    input logic [PC_W-1:0]   boundary
);

    p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pc == '0 && ctrl == '0 && !done && boundary == PC_TERM));

    p_start_load_r2: assert property (@(posedge clk) disable iff (rst)
        (!running && start) |=> (pc == PC_FIRST));

    p_term_done_r7: assert property (@(posedge clk) disable iff (rst)
        (running && !halt && step_next == PC_TERM) |=> (done && pc == PC_TERM));

    p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_idle_nop_r7: assert property (@(posedge clk) disable iff (rst)
        !running |=> (ctrl == '0));

    p_halt_freeze_r8: assert property (@(posedge clk) disable iff (rst)
        (running && halt) |=> ($stable(pc) && ctrl == '0));

    p_cfg_locked_r9: assert property (@(posedge clk) disable iff (rst)
        running |=> $stable(boundary));

endmodule

bind patch_seq psq_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .halt      (halt),
    .running   (running_q),
    .pc        (pc_q),
    .ctrl      (ctrl_q),
    .done      (done_q),
    .step_next (step_next),
    .boundary  (boundary)
);

// File: tb/test_patch_seq.sv
`timescale 1ns/1ps
module test_patch_seq;
    import psq_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start = 1'b0;
    logic              halt = 1'b0;
    logic              cfg_we = 1'b0;
    logic [CFG_AW-1:0] cfg_addr = '0;
    logic [CFG_DW-1:0] cfg_wdata = '0;
    logic [CTRL_W-1:0] hw_ctrl;
    logic [PC_W-1:0]   hw_next;
    logic [PC_W-1:0]   pc;
    logic [CTRL_W-1:0] ctrl;
    logic              done;

    int checks = 0;
    int errors = 0;
    bit fin = 0;

    // bench-side copy of the configuration it wrote while idle
    logic [CFG_DW-1:0] m_pm [PM_DEPTH];
    logic              m_ev [N_ENT];
    logic [PC_W-1:0]   m_ea [N_ENT];
    logic [PC_W-1:0]   m_et [N_ENT];
    logic [PC_W-1:0]   m_bnd;

    always #2.5 clk = ~clk;

    // hardwired schedule: pc 1..6 in order, then terminal
    function automatic logic [CTRL_W-1:0] hw_c(input logic [PC_W-1:0] p);
        return CTRL_W'(16'h0100 + 16'(p) * 16'd73);
    endfunction
    function automatic logic [PC_W-1:0] hw_n(input logic [PC_W-1:0] p);
        return (p < 6) ? p + 1 : PC_TERM;
    endfunction

    assign hw_ctrl = hw_c(pc);
    assign hw_next = hw_n(pc);

    // patch words: ctrl in [15:12]=8, other fields vary; next per index
    function automatic logic [CFG_DW-1:0] pm_val(input int i);
        logic [PC_W-1:0] n;
        if (i < 8)       n = PC_W'(i + 1);
        else if (i == 10) n = PC_W'(4);
        else             n = PC_TERM;
        return {n, 16'h8C00 | 16'(i * 37)};
    endfunction

    // model step: {next, ctrl}
    function automatic logic [CFG_DW-1:0] mstep(input logic [PC_W-1:0] p);
        logic [CTRL_W-1:0] c;
        logic [PC_W-1:0]   n;
        if (p > m_bnd) begin
            c = m_pm[p[PM_AW-1:0]][CTRL_W-1:0];
            n = m_pm[p[PM_AW-1:0]][CFG_DW-1:CTRL_W];
        end else begin
            c = hw_c(p);
            n = hw_n(p);
        end
        for (int k = N_ENT - 1; k >= 0; k--)
            if (m_ev[k] && m_ea[k] == p) n = m_et[k];
        return {n, c};
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [RG_W-1:0] rg, input int slot, input logic [CFG_DW-1:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = {rg, PM_AW'(slot)}; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        if (rg == RG_PM) m_pm[slot] = d;
        else if (rg == RG_BND) m_bnd = d[PC_W-1:0];
        else begin
            m_ea[slot] = d[PC_W-1:0];
            m_et[slot] = d[2*PC_W-1:PC_W];
            m_ev[slot] = d[2*PC_W];
        end
    endtask

    task automatic set_ent(input int k, input logic v, input int at, input int tg);
        wr(RG_ENT, k, CFG_DW'({v, PC_W'(tg), PC_W'(at)}));
    endtask

    task automatic run(input string req, input int halt_at, input int poke_at);
        logic [PC_W-1:0]   p;
        logic [CFG_DW-1:0] s;
        int steps;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R2", "pc after start", 32'(pc), 32'd1);
        check("R7", "ctrl idle nop", 32'(ctrl), 32'd0);
        p = 1; steps = 0;
        while (steps < 40) begin
            if (steps == halt_at) begin
                halt = 1'b1;
                for (int h = 0; h < 2; h++) begin
                    @(negedge clk);
                    check("R8", "pc held", 32'(pc), 32'(p));
                    check("R8", "ctrl nop in halt", 32'(ctrl), 32'd0);
                end
                halt = 1'b0;
            end
            if (steps == poke_at) begin
                cfg_we = 1'b1; cfg_addr = {RG_BND, PM_AW'(0)}; cfg_wdata = '0;
                start = 1'b1;
            end
            @(negedge clk);
            cfg_we = 1'b0; start = 1'b0;
            s = mstep(p);
            check(req, "ctrl step", 32'(ctrl), 32'(s[CTRL_W-1:0]));
            check(req, "pc step", 32'(pc), 32'(s[CFG_DW-1:CTRL_W]));
            check("R7", "done flag", 32'(done), 32'(s[CFG_DW-1:CTRL_W] == PC_TERM));
            if (s[CFG_DW-1:CTRL_W] == PC_TERM) break;
            p = s[CFG_DW-1:CTRL_W];
            steps++;
        end
        @(negedge clk);
        check("R7", "done single cycle", 32'(done), 32'd0);
        check("R7", "ctrl nop after end", 32'(ctrl), 32'd0);
    endtask

    patch_seq i_patch_seq (
        .clk(clk), .rst(rst), .start(start), .halt(halt),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .hw_ctrl(hw_ctrl), .hw_next(hw_next),
        .pc(pc), .ctrl(ctrl), .done(done)
    );

    initial begin
        repeat (20000) @(posedge clk);
        if (!fin) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < N_ENT; k++) begin
            m_ev[k] = 0; m_ea[k] = 0; m_et[k] = 0;
        end
        for (int i = 0; i < PM_DEPTH; i++) m_pm[i] = '0;
        m_bnd = PC_TERM;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1", "pc reset", 32'(pc), 32'd0);
        check("R1", "ctrl reset", 32'(ctrl), 32'd0);
        check("R1", "done reset", 32'(done), 32'd0);

        // R1 and R3: unpatched hardwired run
        run("R1", -1, -1);

        for (int i = 0; i < PM_DEPTH; i++) wr(RG_PM, i, pm_val(i));
        run("R3", -1, -1);

        // R4, R9 and R10: boundary sweep across the schedule
        for (int b = 0; b < 8; b++) begin
            wr(RG_BND, 0, CFG_DW'(b));
            run("R4", -1, -1);
        end

        // R5: redirect pc 2 into patch word 10, which returns to hardwired pc 4
        wr(RG_BND, 0, CFG_DW'(9));
        set_ent(0, 1'b1, 2, 10);
        run("R5", -1, -1);

        // R6: two valid entries on pc 2, lowest index wins
        set_ent(1, 1'b1, 2, 12);
        run("R6", -1, -1);
        set_ent(0, 1'b0, 2, 10);
        run("R6", -1, -1);
        set_ent(1, 1'b0, 2, 12);
        set_ent(2, 1'b0, 3, 12);
        run("R6", -1, -1);

        // R8: halt in the middle of a patched run
        set_ent(0, 1'b1, 2, 10);
        run("R8", 2, -1);

        // R9 and R2: config write and start while running are ignored
        run("R9", -1, 1);
        run("R2", -1, -1);

        fin = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule